// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. A writer pushes one word on each write-clock rising edge that has `wr_en` high, provided the buffer is not full. A reader pulls words out in the order they were written. Each side keeps its own pointer in binary and in Gray code. The Gray copy crosses to the other domain through a two-flop synchronizer. Each side then works out the fill level from its own pointer and the synchronized copy of the other.

Two settings are captured while the shared reset is held low. After reset they stay fixed until the next reset. The read-mode setting picks between standard reads and fall-through reads:

- In standard mode, a word requested with `rd_en` appears one read clock later, marked by a one-cycle `rd_valid`.
- In fall-through mode, the oldest word is presented on `rd_data` without being asked for, and `rd_valid` holds high while it is there.

The width setting picks between 9-bit words with a depth of 2^ADDR_W and 18-bit words with half that depth, so the number of stored bits is the same either way.

The write side produces full, half-full and almost-full flags. The read side produces empty and almost-empty flags. The two "almost" thresholds are parameters.

Top module: `dual_mode_fifo`

## Requirements
- R1: On a write-clock rising edge with `wr_en` high and `wr_full` low, `wr_data` is stored. Stored words are returned on `rd_data` in the order they were written, including across pointer wrap-around.
- R2: A write attempted while `wr_full` is high is dropped. The fill level stays the same, and the dropped word never appears at the read side.
- R3: In standard mode, a read attempted while `rd_empty` is high produces no `rd_valid` pulse and does not move the read pointer.
- R4: In standard mode, a read accepted on one read-clock edge puts the word on `rd_data` with `rd_valid` high after that same edge, for one cycle.
- R5: In fall-through mode, the oldest stored word appears on `rd_data` with `rd_valid` high without any read request. It stays there until `rd_en` is seen high. `rd_empty` equals the inverse of `rd_valid`.
- R6: With `width_sel` = 0, words are 9 bits (bits 8:0 of the data ports), the depth is 2^ADDR_W, and `rd_data[17:9]` reads zero. With `width_sel` = 1, words are all 18 bits and the depth is 2^(ADDR_W-1).
- R7: `mode_sel` (0 = standard, 1 = fall-through) and `width_sel` are captured only while `rst_n` is low. Changing them after reset has no effect.
- R8: `wr_full` is high exactly when the write side's fill level equals the depth.
- R9: `wr_half_full` is high when the fill level is at least half the depth.
- R10: `wr_almost_full` is high when the fill level is at least the depth minus AF_GAP.
- R11: In standard mode, `rd_empty` is high when no word is stored. `rd_almost_empty` is high when the read side's occupancy is at most AE_LEVEL. In fall-through mode, occupancy includes the word being presented.
- R12: After reset, `rd_empty` and `rd_almost_empty` are high. `wr_full`, `wr_half_full`, `wr_almost_full` and `rd_valid` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, synchronous in each clock domain |
| mode_sel | input | 1 | Read mode, captured during reset: 0 standard, 1 fall-through |
| width_sel | input | 1 | Word width, captured during reset: 0 is 9 bits, 1 is 18 bits |
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word (bits 8:0 only in 9-bit mode) |
| wr_full | output | 1 | Fill level equals depth |
| wr_half_full | output | 1 | Fill level at least half the depth |
| wr_almost_full | output | 1 | Fill level at least depth minus AF_GAP |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read request (standard) or acknowledge (fall-through) |
| rd_data | output | 18 | Read word |
| rd_valid | output | 1 | Marks `rd_data` as holding a word |
| rd_empty | output | 1 | No word available at the read side |
| rd_almost_empty | output | 1 | Read-side occupancy at most AE_LEVEL |

## Verification
The assertions watch several properties on every cycle:
- each pointer's Gray code changes by at most one bit per cycle;
- the write pointer holds while full, and the read pointer holds while storage is empty;
- the write-side fill level never exceeds the depth;
- full implies half full and almost full;
- a standard read is followed by `rd_valid`, and a presented fall-through word holds until acknowledged;
- the captured configuration never moves outside reset.

Only the bench's scenarios can show the rest: that data come back intact and in order after wrapping, that overflow and underflow leave no trace in the returned stream, and the exact fill level at which each flag switches. The same goes for the halved depth in 18-bit mode, and for a setting change made after reset being ignored.

// File: rtl/dmf_pkg.sv
// Shared definitions for the dual-mode FIFO.
// Assumes a lane is 9 bits and that the wide word is exactly two lanes.
package dmf_pkg;
    localparam int LANE_W = 9;
    localparam int WIDE_W = 2 * LANE_W;

    typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;
    typedef enum logic {WD_9 = 1'b0, WD_18 = 1'b1} width_e;

    typedef struct packed {
        rd_mode_e mode;
        width_e   width;
    } cfg_t;
endpackage

// File: rtl/dmf_sync2.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes at most one bit of d changes between destination clock edges.
module dmf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Purpose: resample the foreign-domain bus through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dmf_ptr.sv
// Pointer with binary and Gray copies. In wide mode the top bit is held at
// zero, so the pointer wraps at half range and stays a valid Gray sequence.
// Assumes `wide` is constant outside reset.
module dmf_ptr #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          adv,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] gray
);
    logic [PW-1:0] mask;
    logic [PW-1:0] nxt;

    assign mask = wide ? {1'b0, {(PW-1){1'b1}}} : {PW{1'b1}};
    assign nxt  = (bin + 1'b1) & mask;

    // Purpose: step both pointer copies together on each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else if (adv) begin
            bin  <= nxt;
            gray <= nxt ^ (nxt >> 1);
        end
    end

    // R1: a pointer crossing domains may flip at most one Gray bit per cycle
    a_r1_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(gray ^ $past(gray)));
endmodule

// File: rtl/dmf_store.sv
// Storage split into two 9-bit banks that share one row address.
// In narrow mode one bank is written per word. In wide mode both are.
// The write is clocked. The read is combinational and registered by the
// caller. The banks have no reset.
module dmf_store
    import dmf_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic              wr_clk,
    input  logic [1:0]        we,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [WIDE_W-1:0] wr_word,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [WIDE_W-1:0] rd_word
);
    localparam int ROWS = 1 << ROW_W;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [LANE_W-1:0] mem [ROWS];

        // Purpose: store this bank's lane when its enable is set.
        always_ff @(posedge wr_clk) begin
            if (we[b]) mem[wr_row] <= wr_word[b*LANE_W +: LANE_W];
        end

        assign rd_word[b*LANE_W +: LANE_W] = mem[rd_row];
    end
endmodule

// File: rtl/dual_mode_fifo.sv
// Dual-clock FIFO with a read mode and a word width chosen at reset, and
// five status flags. Assumes rst_n is held low for at least three edges of
// each clock, with mode_sel and width_sel stable during that time.
// Flags on the write side are pessimistic with respect to read progress, and
// flags on the read side are pessimistic with respect to write progress, by
// the two-flop crossing delay.
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int AE_LEVEL = 4,
    parameter int AF_GAP   = 4
) (
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              width_sel,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [WIDE_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_half_full,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [WIDE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_empty,
    output logic              rd_almost_empty
);
    localparam int            PW      = ADDR_W + 1;
    localparam int            ROW_W   = ADDR_W - 1;
    localparam logic [PW-1:0] DEPTH_N = PW'(1) << ADDR_W;
    localparam logic [PW-1:0] DEPTH_W = PW'(1) << ROW_W;
    localparam logic [PW-1:0] FULL_M  = {PW{1'b1}};
    localparam logic [PW-1:0] HALF_M  = {1'b0, {(PW-1){1'b1}}};

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // ---------------- write domain ----------------
    cfg_t          w_cfg;
    logic          w_wide;
    logic          w_push;
    logic [PW-1:0] w_bin, w_gray, r_gray_w, r_bin_w;
    logic [PW-1:0] w_mask, w_cnt, w_depth;

    // Purpose: capture the configuration for the write side while reset is low.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) w_cfg <= cfg_t'{mode: rd_mode_e'(mode_sel), width: width_e'(width_sel)};
    end

    assign w_wide  = (w_cfg.width == WD_18);
    assign w_mask  = w_wide ? HALF_M : FULL_M;
    assign w_depth = w_wide ? DEPTH_W : DEPTH_N;
    assign w_push  = wr_en && !wr_full;

    dmf_ptr #(.PW(PW)) u_wptr (
        .clk (wr_clk), .rst_n (rst_n), .wide (w_wide), .adv (w_push),
        .bin (w_bin), .gray (w_gray)
    );

    dmf_sync2 #(.W(PW)) u_r2w (
        .clk (wr_clk), .rst_n (rst_n), .d (r_gray), .q (r_gray_w)
    );

    assign r_bin_w        = gray_to_bin(r_gray_w);
    assign w_cnt          = (w_bin - r_bin_w) & w_mask;
    assign wr_full        = (w_cnt == w_depth);
    assign wr_half_full   = (w_cnt >= (w_depth >> 1));
    assign wr_almost_full = (w_cnt >= (w_depth - PW'(AF_GAP)));

    // ---------------- storage ----------------
    logic [1:0]        st_we;
    logic [ROW_W-1:0]  st_wr_row, st_rd_row;
    logic [WIDE_W-1:0] st_wr_word, st_rd_word;

    assign st_we      = !w_push ? 2'b00 : (w_wide ? 2'b11 : (w_bin[0] ? 2'b10 : 2'b01));
    assign st_wr_row  = w_wide ? w_bin[ROW_W-1:0] : w_bin[ADDR_W-1:1];
    assign st_wr_word = w_wide ? wr_data : {wr_data[LANE_W-1:0], wr_data[LANE_W-1:0]};

    dmf_store #(.ROW_W(ROW_W)) u_store (
        .wr_clk (wr_clk), .we (st_we), .wr_row (st_wr_row), .wr_word (st_wr_word),
        .rd_row (st_rd_row), .rd_word (st_rd_word)
    );

    // ---------------- read domain ----------------
    cfg_t              r_cfg;
    logic              r_wide, r_std;
    logic              r_pop, r_mem_empty, r_held;
    logic [PW-1:0]     r_bin, r_gray, w_gray_r, w_bin_r;
    logic [PW-1:0]     r_mask, r_mem_cnt;
    logic [PW:0]       r_occ;
    logic [WIDE_W-1:0] r_head;

    // Purpose: capture the configuration for the read side while reset is low.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) r_cfg <= cfg_t'{mode: rd_mode_e'(mode_sel), width: width_e'(width_sel)};
    end

    assign r_wide = (r_cfg.width == WD_18);
    assign r_std  = (r_cfg.mode == RD_STD);
    assign r_mask = r_wide ? HALF_M : FULL_M;

    dmf_sync2 #(.W(PW)) u_w2r (
        .clk (rd_clk), .rst_n (rst_n), .d (w_gray), .q (w_gray_r)
    );

    assign w_bin_r     = gray_to_bin(w_gray_r);
    assign r_mem_cnt   = (w_bin_r - r_bin) & r_mask;
    assign r_mem_empty = (r_mem_cnt == '0);
    assign r_pop       = !r_mem_empty && (r_std ? rd_en : (!rd_valid || rd_en));

    dmf_ptr #(.PW(PW)) u_rptr (
        .clk (rd_clk), .rst_n (rst_n), .wide (r_wide), .adv (r_pop),
        .bin (r_bin), .gray (r_gray)
    );

    assign st_rd_row = r_wide ? r_bin[ROW_W-1:0] : r_bin[ADDR_W-1:1];
    assign r_head    = r_wide ? st_rd_word
                     : {{LANE_W{1'b0}}, (r_bin[0] ? st_rd_word[WIDE_W-1:LANE_W]
                                                  : st_rd_word[LANE_W-1:0])};

    // Purpose: load the output word and track whether it holds data.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (r_pop) rd_data <= r_head;
            if (r_std)       rd_valid <= r_pop;
            else if (r_pop)  rd_valid <= 1'b1;
            else if (rd_en)  rd_valid <= 1'b0;
        end
    end

    assign r_held          = !r_std && rd_valid;
    assign r_occ           = {1'b0, r_mem_cnt} + (PW+1)'(r_held);
    assign rd_empty        = r_std ? r_mem_empty : !rd_valid;
    assign rd_almost_empty = (r_occ <= (PW+1)'(AE_LEVEL));

    // ---------------- assertions ----------------
    // R2: a full buffer never advances the write pointer
    a_r2_hold_when_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_full |=> (w_bin == $past(w_bin)));
    // R8: the write-side fill level never exceeds the configured depth
    a_r8_count_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
        w_cnt <= w_depth);
    // R10: full implies the lower write-side thresholds are also reached
    a_r10_full_implies: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_full |-> (wr_almost_full && wr_half_full));
    // R3: empty storage never advances the read pointer
    a_r3_hold_when_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        r_mem_empty |=> (r_bin == $past(r_bin)));
    // R4: an accepted standard read yields valid data on the next cycle
    a_r4_std_latency: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (r_std && rd_en && !rd_empty) |=> rd_valid);
    // R5: a presented fall-through word holds until acknowledged
    a_r5_fwft_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!r_std && rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
    // R11: in standard mode empty implies almost empty
    a_r11_empty_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (r_std && rd_empty) |-> rd_almost_empty);
    // R7: captured configuration is frozen outside reset (both domains)
    a_r7_wcfg_frozen: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> $stable(w_cfg));
    a_r7_rcfg_frozen: assert property (@(posedge rd_clk) disable iff (!rst_n)
        1'b1 |=> $stable(r_cfg));
endmodule

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
    localparam int ADDR_W = 4;
    localparam int AE_LVL = 2;
    localparam int AF_GP  = 2;

    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0, width_sel = 1'b0;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        wr_full, wr_half_full, wr_almost_full;
    logic [17:0] rd_data;
    logic        rd_valid, rd_empty, rd_almost_empty;

    int n_checks = 0;
    int n_fail   = 0;
    int seq      = 0;
    int depth_m  = 16;
    logic wide_m = 1'b0;
    logic finished = 1'b0;
    logic [17:0] sb[$];

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    dual_mode_fifo #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LVL), .AF_GAP(AF_GP)) u_dut (
        .rst_n (rst_n), .mode_sel (mode_sel), .width_sel (width_sel),
        .wr_clk (wr_clk), .wr_en (wr_en), .wr_data (wr_data),
        .wr_full (wr_full), .wr_half_full (wr_half_full), .wr_almost_full (wr_almost_full),
        .rd_clk (rd_clk), .rd_en (rd_en), .rd_data (rd_data), .rd_valid (rd_valid),
        .rd_empty (rd_empty), .rd_almost_empty (rd_almost_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic do_reset(input logic m, input logic w);
        @(negedge wr_clk);
        rst_n = 1'b0; mode_sel = m; width_sel = w; wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(negedge wr_clk);
        rst_n = 1'b1;
        sb.delete();
        wide_m = w;
        depth_m = w ? 8 : 16;
        settle();
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            seq++;
            wr_data = 18'(seq * 5417 + 77);
            wr_en = 1'b1;
            if (sb.size() < depth_m) sb.push_back(wide_m ? wr_data : {9'd0, wr_data[8:0]});
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // standard-mode reads, one request per two cycles
    task automatic rd_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
            if (sb.size() > 0) begin
                chk("R4 rd_valid after read", 32'(rd_valid), 32'd1);
                chk("R1/R6 read data order", 32'(rd_data), 32'(sb.pop_front()));
            end else begin
                chk("R3 no valid on empty read", 32'(rd_valid), 32'd0);
            end
        end
    endtask

    // fall-through acknowledge: the next word must replace the current one
    task automatic ft_ack();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        void'(sb.pop_front());
        if (sb.size() > 0) begin
            chk("R5 next word presented", 32'(rd_valid), 32'd1);
            chk("R5 presented data", 32'(rd_data), 32'(sb[0]));
        end else begin
            chk("R5 valid drops when drained", 32'(rd_valid), 32'd0);
            chk("R5 empty is inverse valid", 32'(rd_empty), 32'd1);
        end
    endtask

    task automatic chk_flags(input logic [4:0] f, input int step);
        chk($sformatf("R8 full step %0d", step), 32'(wr_full), 32'(f[4]));
        chk($sformatf("R9 half step %0d", step), 32'(wr_half_full), 32'(f[3]));
        chk($sformatf("R10 almost_full step %0d", step), 32'(wr_almost_full), 32'(f[2]));
        chk($sformatf("R11 empty step %0d", step), 32'(rd_empty), 32'(f[1]));
        chk($sformatf("R11 almost_empty step %0d", step), 32'(rd_almost_empty), 32'(f[0]));
    endtask

    // {read?, count, {full, half, almost_full, empty, almost_empty}}
    // narrow standard mode: depth 16, half at 8, almost full at 14, almost empty at <=2
    localparam logic [10:0] STEPS [12] = '{
        {1'b0, 5'd2, 5'b00001},
        {1'b0, 5'd1, 5'b00000},
        {1'b0, 5'd5, 5'b01000},
        {1'b0, 5'd5, 5'b01000},
        {1'b0, 5'd1, 5'b01100},
        {1'b0, 5'd1, 5'b01100},
        {1'b0, 5'd1, 5'b11100},
        {1'b0, 5'd3, 5'b11100},   // R2 overflow attempts
        {1'b1, 5'd9, 5'b00000},
        {1'b1, 5'd5, 5'b00001},
        {1'b1, 5'd2, 5'b00011},
        {1'b1, 5'd2, 5'b00011}    // R3 underflow attempts
    };

    initial begin
        do_reset(1'b0, 1'b0);
        // R12 reset state
        chk_flags(5'b00011, 0);
        chk("R12 rd_valid reset", 32'(rd_valid), 32'd0);
        chk("R12 rd_data reset", 32'(rd_data), 32'd0);

        for (int i = 0; i < 12; i++) begin
            if (STEPS[i][10]) rd_burst(int'(STEPS[i][9:5]));
            else              wr_burst(int'(STEPS[i][9:5]));
            settle();
            chk_flags(STEPS[i][4:0], i + 1);
        end
        // pointers intact after overflow/underflow and wrap-around (R1, R2, R3)
        wr_burst(3);
        settle();
        rd_burst(3);
        settle();
        chk("R3 empty after drain", 32'(rd_empty), 32'd1);

        // R5 fall-through mode
        do_reset(1'b1, 1'b0);
        chk("R5 empty before any write", 32'(rd_empty), 32'd1);
        chk("R5 no valid before any write", 32'(rd_valid), 32'd0);
        wr_burst(1);
        settle();
        chk("R5 word falls through", 32'(rd_valid), 32'd1);
        chk("R5 fall-through data", 32'(rd_data), 32'(sb[0]));
        chk("R5 empty low when presented", 32'(rd_empty), 32'd0);
        chk("R11 held word counts, occ 1", 32'(rd_almost_empty), 32'd1);
        ft_ack();
        wr_burst(3);
        settle();
        chk("R5 first of three presented", 32'(rd_data), 32'(sb[0]));
        chk("R11 occupancy 3 above level", 32'(rd_almost_empty), 32'd0);
        ft_ack();
        ft_ack();
        ft_ack();

        // R6 wide mode, depth 8
        do_reset(1'b0, 1'b1);
        wr_burst(7);
        settle();
        chk("R6 not full at 7 wide", 32'(wr_full), 32'd0);
        chk("R10 almost full at 7 wide", 32'(wr_almost_full), 32'd1);
        wr_burst(2);
        settle();
        chk("R6 full at 8 wide", 32'(wr_full), 32'd1);
        rd_burst(8);
        settle();
        chk("R11 wide drained empty", 32'(rd_empty), 32'd1);

        // R7 settings changed without reset have no effect
        mode_sel = 1'b1;
        width_sel = 1'b0;
        wr_burst(1);
        settle();
        chk("R7 no fall-through after late change", 32'(rd_valid), 32'd0);
        chk("R7 standard empty still low", 32'(rd_empty), 32'd0);
        rd_burst(1);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge wr_clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule